// File: doc/BRIEF.md
# Power-Down Entry Gate

This block sits between the CPU's sleep request and the clock-stop logic, and decides whether a sleep request is honoured. The CPU raises a one-cycle strobe to ask for power-down. The block first waits until the external bus write path is idle, so that no write is left half-finished. It then looks at the wake-up source chosen by a configuration bit. That source is either a non-maskable interrupt line or a group of port pins, each pin with its own enable bit and its own active-level bit. If the chosen source is already active, the request is dropped and a one-cycle "ignored" pulse is given. Otherwise the power-down output goes high and stays high until the chosen source becomes active.

The interrupt line and the port pins pass through a two-flop synchronizer before any decision uses them. A watchdog reset input brings the block back to normal running from any state, so a timeout can always recover the chip.

There are three states: RUN (normal operation), DRAIN (waiting for the write path to go idle, then evaluating the request) and PWRDN (sleeping). The transitions are:
- RUN→DRAIN: request strobe.
- DRAIN→DRAIN: bus busy.
- DRAIN→PWRDN: bus idle and wake source inactive (accept).
- DRAIN→RUN: bus idle and wake source active (drop).
- PWRDN→PWRDN: no wake.
- PWRDN→RUN: wake.
- Any state→RUN: watchdog reset.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset the block is in RUN with `pd_active` and `req_ignored` both 0.
- R2: With `wake_sel`=0, the bus idle and the synchronized `nmi_in` low, a request strobe sampled at clock edge k gives `pd_active`=1 after edge k+1.
- R3: With `wake_sel`=0 and the synchronized `nmi_in` high, a request is dropped. `req_ignored` is 1 for exactly the one cycle after edge k+1, and `pd_active` stays 0.
- R4: With `wake_sel`=1, pin i is active when `wake_en[i]`=1 and `wake_pins[i]`==`wake_pol[i]` (pol 1 = active high, pol 0 = active low). Any active pin causes the request to be dropped with an R3-style pulse. Pins whose enable bit is 0 never count.
- R5: With `wake_sel`=1 and no pin active per R4, a request is accepted as in R2.
- R6: While `bus_busy` is 1 after a request, the block waits in DRAIN with both outputs 0. The request is evaluated once, at the first edge where `bus_busy` is 0, using the wake state at that edge.
- R7: In PWRDN, `pd_active` stays 1 while the selected source is inactive. The source that is not selected has no effect.
- R8: Wake from PWRDN happens when `nmi_in` goes high (`wake_sel`=0) or when any pin becomes active per R4 (`wake_sel`=1). `pd_active` is still 1 after the second edge following the input change and is 0 after the third.
- R9: `wdt_rst`=1 at an edge forces RUN with `pd_active`=0 after that edge, from any state, and gives no ignored pulse.
- R10: A request strobe while in DRAIN or PWRDN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_rst | input | 1 | Watchdog reset, forces RUN |
| pd_req | input | 1 | One-cycle power-down request strobe |
| bus_busy | input | 1 | External write path has a pending write |
| wake_sel | input | 1 | Wake source: 0 interrupt line, 1 port pins |
| nmi_in | input | 1 | Non-maskable interrupt line (active high wakes) |
| wake_pins | input | NUM_PINS | Port wake-up pins |
| wake_en | input | NUM_PINS | Per-pin wake enable |
| wake_pol | input | NUM_PINS | Per-pin active level |
| pd_active | output | 1 | Registered power-down output |
| req_ignored | output | 1 | One-cycle pulse when a request is dropped |

## Verification
The hardest situation to reach from the ports is a wake-source change that happens while the block waits in DRAIN. The decision must use the level present when the bus goes idle, not the level present when the strobe arrived. The bench holds `bus_busy` high, sends the strobe, moves the interrupt line and waits out the synchronizer delay, and only then releases the bus. It does this in both directions, so it sees both a late drop and a late accept. The pin path is swept over every combination of enable, polarity and pin level of a four-pin configuration, and each accepted case is woken through its lowest enabled pin.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PWRDN = 2'd2
    } pgc_state_t;
endpackage

// File: rtl/pgc_sync.sv
module pgc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/pgc_wake_eval.sv
module pgc_wake_eval #(
    parameter int NUM_PINS = 4
) (
    input  logic                nmi_s_i,
    input  logic [NUM_PINS-1:0] pins_s_i,
    input  logic [NUM_PINS-1:0] en_i,
    input  logic [NUM_PINS-1:0] pol_i,
    input  logic                sel_i,
    output logic                wake_act_o
);
    logic [NUM_PINS-1:0] hit;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign hit[p] = en_i[p] & (pins_s_i[p] ~^ pol_i[p]);
    end

    assign wake_act_o = sel_i ? (|hit) : nmi_s_i;
endmodule

// File: rtl/pgc_fsm.sv
module pgc_fsm
    import pgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_rst_i,
    input  logic pd_req_i,
    input  logic bus_busy_i,
    input  logic wake_act_i,
    output logic pd_active_o,
    output logic req_ignored_o
);
    pgc_state_t state_q, state_d;
    logic       drop_now;

    always_comb begin
        state_d  = state_q;
        drop_now = 1'b0;
        if (wdt_rst_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (pd_req_i) state_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!bus_busy_i) begin
                        if (wake_act_i) begin
                            state_d  = ST_RUN;
                            drop_now = 1'b1;
                        end else begin
                            state_d = ST_PWRDN;
                        end
                    end
                end
                ST_PWRDN: begin
                    if (wake_act_i) state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_active_o   <= 1'b0;
            req_ignored_o <= 1'b0;
        end else begin
            pd_active_o   <= (state_d == ST_PWRDN);
            req_ignored_o <= drop_now;
        end
    end

    assert_rise_from_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active_o) |-> $past(state_q == ST_DRAIN && !bus_busy_i && !wake_act_i && !wdt_rst_i));

    assert_drop_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ignored_o |=> !req_ignored_o);

    assert_outputs_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_active_o && req_ignored_o));

    assert_drain_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && bus_busy_i && !wdt_rst_i)
        |=> (state_q == ST_DRAIN && !pd_active_o && !req_ignored_o));

    assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRDN && !wake_act_i && !wdt_rst_i) |=> pd_active_o);

    assert_wake_exits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRDN && wake_act_i) |=> !pd_active_o);

    assert_wdt_forces_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_i |=> (state_q == ST_RUN && !pd_active_o && !req_ignored_o));
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wdt_rst,
    input  logic                pd_req,
    input  logic                bus_busy,
    input  logic                wake_sel,
    input  logic                nmi_in,
    input  logic [NUM_PINS-1:0] wake_pins,
    input  logic [NUM_PINS-1:0] wake_en,
    input  logic [NUM_PINS-1:0] wake_pol,
    output logic                pd_active,
    output logic                req_ignored
);
    localparam int SYNC_W = NUM_PINS + 1;

    logic [SYNC_W-1:0]   raw_in, sync_out;
    logic                nmi_s;
    logic [NUM_PINS-1:0] pins_s;
    logic                wake_act;

    assign raw_in = {nmi_in, wake_pins};
    assign nmi_s  = sync_out[SYNC_W-1];
    assign pins_s = sync_out[NUM_PINS-1:0];

    pgc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    pgc_wake_eval #(.NUM_PINS(NUM_PINS)) u_eval (
        .nmi_s_i    (nmi_s),
        .pins_s_i   (pins_s),
        .en_i       (wake_en),
        .pol_i      (wake_pol),
        .sel_i      (wake_sel),
        .wake_act_o (wake_act)
    );

    pgc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdt_rst_i     (wdt_rst),
        .pd_req_i      (pd_req),
        .bus_busy_i    (bus_busy),
        .wake_act_i    (wake_act),
        .pd_active_o   (pd_active),
        .req_ignored_o (req_ignored)
    );
endmodule

// File: tb/tb_pwr_gate_ctrl.sv
module tb_pwr_gate_ctrl;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdt_rst = 1'b0, pd_req = 1'b0, bus_busy = 1'b0, wake_sel = 1'b0, nmi_in = 1'b0;
    logic [NP-1:0] wake_pins = '0, wake_en = '0, wake_pol = '0;
    logic pd_active, req_ignored;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pwr_gate_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .pd_req(pd_req),
        .bus_busy(bus_busy), .wake_sel(wake_sel), .nmi_in(nmi_in),
        .wake_pins(wake_pins), .wake_en(wake_en), .wake_pol(wake_pol),
        .pd_active(pd_active), .req_ignored(req_ignored)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        pd_req = 1'b1;
        tick(1);
        pd_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 pd", pd_active, 1'b0);
        check("R1 ign", req_ignored, 1'b0);
        rst_n = 1'b1;
        tick(2);
        check("R1 pd after release", pd_active, 1'b0);

        // R2 + R7 + R10 + R8: interrupt-line source, pins active but not selected
        wake_sel = 1'b0; nmi_in = 1'b0;
        wake_en = '1; wake_pol = '1; wake_pins = '1;
        tick(3);
        strobe();
        check("R2 not yet", pd_active, 1'b0);
        tick(1);
        check("R2 pd", pd_active, 1'b1);
        check("R2 ign", req_ignored, 1'b0);
        tick(5);
        check("R7 unselected pins", pd_active, 1'b1);
        strobe();
        tick(1);
        check("R10 pd", pd_active, 1'b1);
        check("R10 ign", req_ignored, 1'b0);
        nmi_in = 1'b1;
        tick(2);
        check("R8 sync delay", pd_active, 1'b1);
        tick(1);
        check("R8 wake nmi", pd_active, 1'b0);

        // R3: request while interrupt line high
        tick(2);
        strobe();
        tick(1);
        check("R3 ign", req_ignored, 1'b1);
        check("R3 pd", pd_active, 1'b0);
        tick(1);
        check("R3 pulse end", req_ignored, 1'b0);

        // R6: late drop while draining
        nmi_in = 1'b0; bus_busy = 1'b1;
        tick(3);
        strobe();
        tick(4);
        check("R6 wait pd", pd_active, 1'b0);
        check("R6 wait ign", req_ignored, 1'b0);
        strobe(); // R10: extra strobe in DRAIN
        nmi_in = 1'b1;
        tick(3);
        bus_busy = 1'b0;
        tick(1);
        check("R6 late drop ign", req_ignored, 1'b1);
        check("R6 late drop pd", pd_active, 1'b0);
        tick(1);
        check("R10 no second eval", req_ignored, 1'b0);

        // R6: late accept while draining
        bus_busy = 1'b1;
        tick(3);
        strobe();
        nmi_in = 1'b0;
        tick(4);
        check("R6 busy hold", pd_active, 1'b0);
        bus_busy = 1'b0;
        tick(1);
        check("R6 late accept", pd_active, 1'b1);
        wdt_rst = 1'b1;
        tick(1);
        wdt_rst = 1'b0;
        check("R9 exit from sleep", pd_active, 1'b0);

        // R9: watchdog during DRAIN
        bus_busy = 1'b1;
        strobe();
        wdt_rst = 1'b1;
        tick(1);
        wdt_rst = 1'b0;
        bus_busy = 1'b0;
        tick(2);
        check("R9 drain pd", pd_active, 1'b0);
        check("R9 drain ign", req_ignored, 1'b0);

        // R4/R5/R8: sweep of the pin source; nmi high must not matter (R7)
        wake_sel = 1'b1; nmi_in = 1'b1;
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 16; p++) begin
                for (int v = 0; v < 16; v++) begin
                    logic [NP-1:0] en, pol, pin;
                    logic act;
                    en = NP'(e); pol = NP'(p); pin = NP'(v);
                    act = |(en & ~(pin ^ pol));
                    wake_en = en; wake_pol = pol; wake_pins = pin;
                    tick(3);
                    strobe();
                    tick(1);
                    check("R4 ignored", req_ignored, act);
                    check("R5 entered", pd_active, ~act);
                    if (act) begin
                        tick(1);
                    end else if (en != '0) begin
                        int b;
                        b = 0;
                        for (int i = NP - 1; i >= 0; i--) if (en[i]) b = i;
                        wake_pins[b] = pol[b];
                        tick(2);
                        check("R8 pin sync delay", pd_active, 1'b1);
                        tick(1);
                        check("R8 pin wake", pd_active, 1'b0);
                    end else begin
                        wdt_rst = 1'b1;
                        tick(1);
                        wdt_rst = 1'b0;
                        check("R9 sweep exit", pd_active, 1'b0);
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule